// File: doc/BRIEF.md
# Microstep Control Sequencer

This block is the hardwired control unit of a single-bus processor datapath. It steps through fixed sequences of control steps. Each step drives a set of bus-gate strobes, ALU controls and memory request levels for the datapath around it. The sequencer decodes four kinds of operation:

- a three-step instruction fetch, in which the program counter increment overlaps the pending memory read;
- a register-to-register subtract;
- an add whose second operand is read from memory through a register pointer, with the result written back to the same address;
- a store to a pointer-plus-displacement address, where the displacement comes from a second instruction word.

Memory is reached through a read level, a write level and a completion acknowledge (`mfc`). Certain steps wait for that acknowledge. While a step waits, the sequencer holds in that step with its outputs unchanged until `mfc` is sampled high, and moves on one cycle later. The instruction word is taken from `instr` during the step that loads the instruction register. Its top two bits select the operation, and two 3-bit register fields sit in its low bits.

Top module: `step_sequencer`

## Requirements
- R1: After reset, and at the start of every instruction, the first fetch step drives pc_out, mar_in, mem_read, y_clr, c_in and z_in together, with alu_sub low.
- R2: The second fetch step drives z_out, pc_in and mem_read, and waits for `mfc`.
- R3: The third fetch step drives mdr_out and ir_in with mem_read low. It samples `instr`, where bits [15:14] are the opcode, bits [5:3] are the source register field and bits [2:0] are the destination or pointer field.
- R4: In a step that waits for `mfc`, every output stays unchanged while `mfc` is low. The next step appears in the cycle after `mfc` is sampled high. In a step that does not wait, `mfc` has no effect.
- R5: Opcode 00 (subtract) runs three execute steps. The first has rf_out with the source field and y_in. The second has rf_out with the destination field, alu_sub and z_in. The third has z_out and rf_in with the destination field.
- R6: Opcode 01 (indirect add) runs five execute steps:
  - rf_out(pointer), mar_in and mem_read;
  - rf_out(source), y_in and mem_read, waiting for `mfc`;
  - mdr_out and z_in;
  - z_out, mdr_in and mem_write, waiting for `mfc`;
  - a step with every output low.
- R7: Opcode 10 (indexed store) repeats the first two fetch steps for the displacement word. It then runs five more steps:
  - mdr_out and y_in;
  - rf_out(pointer) and z_in, with c_in low;
  - z_out and mar_in;
  - rf_out(source), mdr_in and mem_write, waiting for `mfc`;
  - a step with every output low.
- R8: mem_read and mem_write are never high in the same cycle.
- R9: Opcode 11 returns to the first fetch step immediately after the third fetch step. It raises no rf_in, mdr_in or mem_write.
- R10: After the last step of any instruction, the next cycle is the first fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word on the bus while the data register drives it |
| mfc | input | 1 | Memory completion acknowledge |
| pc_out | output | 1 | Program counter drives bus |
| pc_in | output | 1 | Program counter loads from bus |
| mar_in | output | 1 | Address register loads from bus |
| mdr_out | output | 1 | Data register drives bus |
| mdr_in | output | 1 | Data register loads from bus |
| ir_in | output | 1 | Instruction register loads from bus |
| y_in | output | 1 | Operand register Y loads from bus |
| y_clr | output | 1 | Operand register Y clears |
| c_in | output | 1 | ALU carry input |
| z_in | output | 1 | Result register Z loads from ALU |
| z_out | output | 1 | Result register Z drives bus |
| alu_sub | output | 1 | ALU subtracts (low: adds) |
| rf_out | output | 1 | Selected register file entry drives bus |
| rf_in | output | 1 | Selected register file entry loads from bus |
| rf_sel | output | 3 | Register file entry select |
| mem_read | output | 1 | Memory read request level |
| mem_write | output | 1 | Memory write request level |

## Verification
Each opcode is issued with random register fields and random acknowledge delays. This shows that the register select follows the correct field in every step and that each waiting step holds for exactly as long as `mfc` stays low. Zero-delay acknowledges check that the sequencer advances in the very next cycle. Long delays check that the outputs hold steady. Random `mfc` values in steps that do not wait show that the acknowledge is ignored there. Back-to-back instructions, including the unused opcode, show that every sequence returns to the first fetch step.

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int W  = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  instr,
  input  logic          mfc,
  output logic          pc_out,
  output logic          pc_in,
  output logic          mar_in,
  output logic          mdr_out,
  output logic          mdr_in,
  output logic          ir_in,
  output logic          y_in,
  output logic          y_clr,
  output logic          c_in,
  output logic          z_in,
  output logic          z_out,
  output logic          alu_sub,
  output logic          rf_out,
  output logic          rf_in,
  output logic [RW-1:0] rf_sel,
  output logic          mem_read,
  output logic          mem_write
);

  typedef enum logic [4:0] {
    F1, F2, F3,
    S1, S2, S3,
    A1, A2, A3, A4, A5,
    M1, M2, M3, M4, M5, M6, M7
  } step_t;

  step_t st, st_nx;
  logic [RW-1:0] src_q, dst_q;
  logic [15:0] cw;
  logic [RW-1:0] sel;
  logic wait_step;
  logic unused_mid;

  assign unused_mid = ^instr[W-3:2*RW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= F1;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      st <= st_nx;
      if (st == F3) begin
        src_q <= instr[2*RW-1:RW];
        dst_q <= instr[RW-1:0];
      end
    end
  end

  assign wait_step = (st == F2) || (st == A2) || (st == A4) || (st == M2) || (st == M6);

  always_comb begin
    st_nx = st;
    case (st)
      F1: st_nx = F2;
      F2: if (mfc) st_nx = F3;
      F3: case (instr[W-1:W-2])
            2'b00:   st_nx = S1;
            2'b01:   st_nx = A1;
            2'b10:   st_nx = M1;
            default: st_nx = F1;
          endcase
      S1: st_nx = S2;
      S2: st_nx = S3;
      S3: st_nx = F1;
      A1: st_nx = A2;
      A2: if (mfc) st_nx = A3;
      A3: st_nx = A4;
      A4: if (mfc) st_nx = A5;
      A5: st_nx = F1;
      M1: st_nx = M2;
      M2: if (mfc) st_nx = M3;
      M3: st_nx = M4;
      M4: st_nx = M5;
      M5: st_nx = M6;
      M6: if (mfc) st_nx = M7;
      M7: st_nx = F1;
      default: st_nx = F1;
    endcase
  end

  // cw bits: pc_out pc_in mar_in mdr_out mdr_in ir_in y_in y_clr c_in z_in z_out alu_sub rf_out rf_in read write
  always_comb begin
    cw  = '0;
    sel = '0;
    case (st)
      F1, M1: cw = 16'b1010_0001_1100_0010;
      F2, M2: cw = 16'b0100_0000_0010_0010;
      F3:     cw = 16'b0001_0100_0000_0000;
      S1: begin cw = 16'b0000_0010_0000_1000; sel = src_q; end
      S2: begin cw = 16'b0000_0000_0101_1000; sel = dst_q; end
      S3: begin cw = 16'b0000_0000_0010_0100; sel = dst_q; end
      A1: begin cw = 16'b0010_0000_0000_1010; sel = dst_q; end
      A2: begin cw = 16'b0000_0010_0000_1010; sel = src_q; end
      A3:     cw = 16'b0001_0000_0100_0000;
      A4:     cw = 16'b0000_1000_0010_0001;
      M3:     cw = 16'b0001_0010_0000_0000;
      M4: begin cw = 16'b0000_0000_0100_1000; sel = dst_q; end
      M5:     cw = 16'b0010_0000_0010_0000;
      M6: begin cw = 16'b0000_1000_0000_1001; sel = src_q; end
      default: cw = '0;
    endcase
  end

  assign {pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in, y_in, y_clr,
          c_in, z_in, z_out, alu_sub, rf_out, rf_in, mem_read, mem_write} = cw;
  assign rf_sel = sel;

  // R8
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_step && !mfc) |=> ($stable(cw) && $stable(rf_sel)));

  // R10
  sub_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_in |=> (pc_out && mar_in && y_clr));

  // R2
  pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_in && !$past(pc_in)) |-> $past(pc_out && z_in));

  // R3
  ir_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_in |-> (!mem_read && $past(mem_read)));

endmodule

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] instr = '0;
  logic mfc = 0;
  logic pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in, y_in, y_clr;
  logic c_in, z_in, z_out, alu_sub, rf_out, rf_in, mem_read, mem_write;
  logic [2:0] rf_sel;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  step_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .mfc(mfc),
    .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mdr_out(mdr_out),
    .mdr_in(mdr_in), .ir_in(ir_in), .y_in(y_in), .y_clr(y_clr), .c_in(c_in),
    .z_in(z_in), .z_out(z_out), .alu_sub(alu_sub), .rf_out(rf_out), .rf_in(rf_in),
    .rf_sel(rf_sel), .mem_read(mem_read), .mem_write(mem_write)
  );

  localparam logic [15:0] PCO = 16'h8000, PCI = 16'h4000, MARI = 16'h2000, MDRO = 16'h1000;
  localparam logic [15:0] MDRI = 16'h0800, IRI = 16'h0400, YI = 16'h0200, YC = 16'h0100;
  localparam logic [15:0] CI = 16'h0080, ZI = 16'h0040, ZO = 16'h0020, SB = 16'h0010;
  localparam logic [15:0] RO = 16'h0008, RI = 16'h0004, RD = 16'h0002, WR = 16'h0001;

  function automatic logic [15:0] obs();
    return {pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in, y_in, y_clr,
            c_in, z_in, z_out, alu_sub, rf_out, rf_in, mem_read, mem_write};
  endfunction

  function automatic int op_len(input logic [1:0] op);
    case (op)
      2'b00: return 6;
      2'b01: return 8;
      2'b10: return 10;
      default: return 3;
    endcase
  endfunction

  // returns {wait, sel[2:0], ctrl[15:0]}
  function automatic logic [19:0] exp_step(input logic [1:0] op, input int k,
                                           input logic [2:0] rs, input logic [2:0] rd);
    logic [15:0] f1, f2;
    f1 = PCO|MARI|YC|CI|ZI|RD;
    f2 = ZO|PCI|RD;
    if (k == 0) return {1'b0, 3'd0, f1};
    if (k == 1) return {1'b1, 3'd0, f2};
    if (k == 2) return {1'b0, 3'd0, MDRO|IRI};
    case (op)
      2'b00: case (k)
        3: return {1'b0, rs, RO|YI};
        4: return {1'b0, rd, RO|SB|ZI};
        default: return {1'b0, rd, ZO|RI};
      endcase
      2'b01: case (k)
        3: return {1'b0, rd, RO|MARI|RD};
        4: return {1'b1, rs, RO|YI|RD};
        5: return {1'b0, 3'd0, MDRO|ZI};
        6: return {1'b1, 3'd0, ZO|MDRI|WR};
        default: return {1'b0, 3'd0, 16'h0};
      endcase
      default: case (k)
        3: return {1'b0, 3'd0, f1};
        4: return {1'b1, 3'd0, f2};
        5: return {1'b0, 3'd0, MDRO|YI};
        6: return {1'b0, rd, RO|ZI};
        7: return {1'b0, 3'd0, ZO|MARI};
        8: return {1'b1, rs, RO|MDRI|WR};
        default: return {1'b0, 3'd0, 16'h0};
      endcase
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] op, input int k, input bit first);
    if (k == 0) return first ? "R1" : "R10";
    if (k == 1) return "R2";
    if (k == 2) return "R3";
    case (op)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check_now(input logic [19:0] e, input string tag);
    logic [15:0] got;
    got = obs();
    tests++;
    if (got !== e[15:0] || ((e[15:0] & (RO|RI)) != 0 && rf_sel !== e[18:16])) begin
      fails++;
      $display("FAIL %s ctrl=%h sel=%0d expected ctrl=%h sel=%0d", tag, got, rf_sel, e[15:0], e[18:16]);
    end
    if (mem_read && mem_write) begin
      fails++;
      $display("FAIL R8 read=%b write=%b expected not both", mem_read, mem_write);
    end
  endtask

  bit first_instr = 1;

  task automatic run_instr(input logic [15:0] w, input int max_delay);
    logic [1:0] op;
    logic [19:0] e;
    op = w[15:14];
    instr = w;
    for (int k = 0; k < op_len(op); k++) begin
      e = exp_step(op, k, w[5:3], w[2:0]);
      if (e[19]) begin
        int d;
        d = (max_delay < 0) ? 5 : int'($urandom_range(max_delay, 0));
        for (int j = 0; j < d; j++) begin
          check_now(e, (j == 0) ? tag_of(op, k, first_instr) : "R4");
          mfc = 0;
          @(negedge clk);
        end
        check_now(e, (d == 0) ? tag_of(op, k, first_instr) : "R4");
        mfc = 1;
      end else begin
        check_now(e, tag_of(op, k, first_instr));
        mfc = 1'($urandom_range(1, 0));
      end
      @(negedge clk);
      first_instr = 0;
    end
  endtask

  initial begin
    void'($urandom(1234));
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_instr(16'h002B, 0);
    run_instr(16'h4031, 0);
    run_instr(16'h8017, 0);
    run_instr(16'hC03F, 0);
    run_instr(16'h0007, -1);
    run_instr(16'h4038, -1);
    run_instr(16'h8005, -1);
    run_instr(16'hC000, 2);
    run_instr(16'h0012, 2);
    for (int i = 0; i < 40; i++) run_instr(16'($urandom()), 3);
    check_now(exp_step(2'b00, 0, 3'd0, 3'd0), "R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule